// File: doc/BRIEF.md
# Segmented Long-Message Receive Buffer

This block sits between a power-delivery message receiver and a host register port. The receiver streams each accepted frame in as bytes, framed by start and end strobes, and the block keeps up to two whole frames in two slots. The host sees one segment of the oldest stored frame at a time. It reads a remaining-byte count, a frame-type code and a data window whose pointer moves forward by one on each read.

A frame of at most 132 bytes fits in one segment. A longer frame, which carries a 4-byte extended header, is split. The first segment holds bytes 0..131 and is announced by a "long message start" alert. When the host clears that alert, the tail of the same frame, from byte 132 onward, is presented as a second segment under the ordinary "message received" alert. When the host clears "message received", the frame is freed and the next stored frame is presented.

The block also handles:
- an overflow flag that mutes acknowledgement;
- a rewind command;
- hard and cable reset events from the receiver.

Top module: `pd_rx_seg_buffer`

## Requirements
- R1: After reset, the alert register (address 0), the count register (address 1), the frame-type register (address 2) and the `ack_en` output all read 0.
- R2: A frame of L bytes with 1 <= L <= 132 raises alert bit 0 ("message received"). The count register then reads L+1, the frame-type register reads the frame's code, and data reads (address 3) return bytes 0..L-1 in order.
- R3: A frame of 133..264 bytes raises alert bit 1 ("long message start") instead of bit 0. The count register then reads 133, and data reads return bytes 0..131.
- R4: Writing 1 to alert bit 1 while it is set discards the first segment and raises bit 0. The count then reads L-131, and data reads continue with frame byte 132.
- R5: Each data read advances the pointer by one byte. Reads of the count or frame-type registers do not move it. A data read at the end of the segment leaves the count at 1.
- R6: Writing code 0xEE to the command register (address 4) rewinds the pointer to the start of the current segment: byte 0 for a first or single segment, byte 132 for a tail segment. Any other code leaves the pointer unchanged.
- R7: After a partial read, the count reads the number of unread segment bytes plus 1. For example, 31 becomes 16 after 15 data reads.
- R8: Writing 1 to alert bit 0 while it is set frees the presented frame, and the next stored frame is presented with its alert raised. Writes of 1 to a clear alert bit, and writes of 0, change nothing.
- R9: Two frames, one of 264 bytes and one of 30 bytes, are held at once. A frame that starts while both slots are full is dropped, alert bit 2 (overflow) is set, and the stored frames stay intact.
- R10: From an overflow until alert bit 0 is next cleared, `ack_en` is all zero. Bit 2 clears only when bits 0 and 2 are written 1 in the same write.
- R11: A hard reset pulse drops all stored frames, clears alert bits 0 and 1, zeroes the acknowledge-enable register, and makes the count read 0.
- R12: A cable reset pulse drops all stored frames and zeroes the acknowledge-enable register. It makes the count read 1, the frame type read 6, and raises alert bit 0. Clearing bit 0 afterwards returns the count to 0.
- R13: The acknowledge-enable register (address 5) is host-writable and readable, and drives `ack_en` when no overflow hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start of a received frame |
| rx_ft | input | FT_W | Frame-type code, sampled with rx_sof |
| rx_we | input | 1 | Received byte strobe |
| rx_wdata | input | 8 | Received byte |
| rx_eof | input | 1 | End of frame; commits it to its slot |
| rx_hard_rst | input | 1 | Hard reset received |
| rx_cable_rst | input | 1 | Cable reset received |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (advances the data pointer) |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr, combinational |
| ack_en | output | N_ACK | Per-frame-type acknowledge enables |

## Verification
On every cycle, the assertions check four things:
- the two start/received alerts are never raised together;
- the data pointer stays inside the presented segment;
- a full slot pair stays full until the host frees a frame;
- the overflow flag only falls on a combined write, and both reset events force their count values on the next cycle.

Only the bench scenarios can show that the bytes come out in order across the split at byte 132, and that a rewind lands on the right byte. The same holds for the next frame being queued behind the current one, and a dropped third frame never appearing. The bench sweeps frame lengths on both sides of the 132/133 boundary up to 264.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [2:0] {
    REG_ALERT = 3'd0,
    REG_COUNT = 3'd1,
    REG_FTYPE = 3'd2,
    REG_DATA  = 3'd3,
    REG_CMD   = 3'd4,
    REG_ACKEN = 3'd5
  } reg_addr_e;

  localparam logic [7:0] CMD_REWIND = 8'hEE;
  localparam int ALB_MSG   = 0;
  localparam int ALB_BEGIN = 1;
  localparam int ALB_OVF   = 2;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int MAX_MSG = 264,
  parameter int FT_W    = 3,
  localparam int LW     = $clog2(MAX_MSG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_sof,
  input  logic [FT_W-1:0] rx_ft,
  input  logic            rx_we,
  input  logic [7:0]      rx_wdata,
  input  logic            rx_eof,
  input  logic            flush,
  input  logic            free_head,
  input  logic [LW-1:0]   rd_ptr,
  output logic            head_valid,
  output logic [LW-1:0]   head_len,
  output logic [FT_W-1:0] head_ft,
  output logic [7:0]      rd_byte,
  output logic            ovf_evt
);
  localparam int MAW = $clog2(2 * MAX_MSG);

  logic [7:0]      mem [2*MAX_MSG];
  logic [LW-1:0]   slot_len   [2];
  logic [LW-1:0]   slot_len_n [2];
  logic [FT_W-1:0] slot_ft    [2];
  logic [FT_W-1:0] slot_ft_n  [2];
  logic            hd, hd_n;
  logic [1:0]      nvalid, nvalid_n;
  logic            wact, wact_n, wdrop, wdrop_n, wsel, wsel_n;
  logic [LW-1:0]   wcnt, wcnt_n;
  logic [FT_W-1:0] wft, wft_n;
  logic            commit, mem_we;
  logic [MAW-1:0]  wr_idx, rd_idx;

  assign commit  = rx_eof & wact & ~wdrop & (wcnt != '0) & ~flush;
  assign mem_we  = rx_we & wact & ~wdrop & (wcnt < LW'(MAX_MSG)) & ~rx_sof & ~flush;
  assign ovf_evt = rx_sof & (nvalid == 2'd2) & ~flush;
  assign wr_idx  = (wsel ? MAW'(MAX_MSG) : '0) + MAW'(wcnt);
  assign rd_idx  = (hd ? MAW'(MAX_MSG) : '0) + MAW'(rd_ptr);

  always_comb begin
    hd_n       = hd;
    nvalid_n   = nvalid;
    wact_n     = wact;
    wdrop_n    = wdrop;
    wsel_n     = wsel;
    wcnt_n     = wcnt;
    wft_n      = wft;
    slot_len_n = slot_len;
    slot_ft_n  = slot_ft;
    if (flush) begin
      hd_n     = 1'b0;
      nvalid_n = 2'd0;
      wact_n   = 1'b0;
    end else begin
      if (rx_sof) begin
        wact_n  = 1'b1;
        wcnt_n  = '0;
        wft_n   = rx_ft;
        wdrop_n = (nvalid == 2'd2);
        wsel_n  = hd ^ (nvalid == 2'd1);
      end else if (mem_we) begin
        wcnt_n = wcnt + 1'b1;
      end
      if (rx_eof) wact_n = 1'b0;
      if (commit) begin
        slot_len_n[wsel] = wcnt;
        slot_ft_n[wsel]  = wft;
      end
      nvalid_n = nvalid + {1'b0, commit} - {1'b0, free_head};
      hd_n     = hd ^ free_head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd       <= 1'b0;
      nvalid   <= 2'd0;
      wact     <= 1'b0;
      wdrop    <= 1'b0;
      wsel     <= 1'b0;
      wcnt     <= '0;
      wft      <= '0;
      slot_len <= '{default: '0};
      slot_ft  <= '{default: '0};
    end else begin
      hd       <= hd_n;
      nvalid   <= nvalid_n;
      wact     <= wact_n;
      wdrop    <= wdrop_n;
      wsel     <= wsel_n;
      wcnt     <= wcnt_n;
      wft      <= wft_n;
      slot_len <= slot_len_n;
      slot_ft  <= slot_ft_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_idx] <= rx_wdata;
  end

  assign head_valid = (nvalid != 2'd0);
  assign head_len   = slot_len[hd];
  assign head_ft    = slot_ft[hd];
  assign rd_byte    = (rd_ptr < LW'(MAX_MSG)) ? mem[rd_idx] : 8'h00;

  p_slots_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nvalid != 2'd3);
  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nvalid == 2'd2 && !free_head && !flush) |=> nvalid == 2'd2);
endmodule

// File: rtl/rxb_present.sv
module rxb_present #(
  parameter int MAX_MSG   = 264,
  parameter int SEG_FIRST = 132,
  parameter int FT_W      = 3,
  parameter int N_ACK     = 3,
  parameter int CABLE_FT  = 6,
  localparam int LW       = $clog2(MAX_MSG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_rst,
  input  logic             cable_rst,
  input  logic             head_valid,
  input  logic [LW-1:0]    head_len,
  input  logic [FT_W-1:0]  head_ft,
  input  logic             ovf_evt,
  input  logic             alert_wr,
  input  logic [2:0]       alert_wdata,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             det_wr,
  input  logic [N_ACK-1:0] det_wdata,
  input  logic             data_rd,
  output logic [LW-1:0]    rd_ptr,
  output logic             free_head,
  output logic [7:0]       cnt,
  output logic [FT_W-1:0]  ftype,
  output logic [2:0]       alerts,
  output logic [N_ACK-1:0] det,
  output logic [N_ACK-1:0] ack_en
);
  import rxb_pkg::*;

  logic             shown, shown_n, seg, seg_n, cable, cable_n;
  logic             msg_a, msg_a_n, beg_a, beg_a_n, ovf, ovf_n, hold, hold_n;
  logic [LW-1:0]    rd_ptr_n, base, seg_end, cnt_full;
  logic [N_ACK-1:0] det_n;
  logic             live, msg_clr, beg_clr, ovf_clr, is_long;

  assign is_long  = head_len > LW'(SEG_FIRST);
  assign base     = seg ? LW'(SEG_FIRST) : '0;
  assign seg_end  = (!seg && is_long) ? LW'(SEG_FIRST) : head_len;
  assign live     = shown & head_valid & ~cable;
  assign msg_clr  = alert_wr & alert_wdata[ALB_MSG] & msg_a;
  assign beg_clr  = alert_wr & alert_wdata[ALB_BEGIN] & beg_a;
  assign ovf_clr  = alert_wr & alert_wdata[ALB_MSG] & alert_wdata[ALB_OVF];
  assign free_head = msg_clr & live;
  assign cnt_full = seg_end - rd_ptr + 1'b1;

  always_comb begin
    if (cable)     cnt = 8'd1;
    else if (live) cnt = 8'(cnt_full);
    else           cnt = 8'd0;
    if (cable)     ftype = FT_W'(CABLE_FT);
    else if (live) ftype = head_ft;
    else           ftype = '0;
  end

  always_comb begin
    shown_n  = shown;
    seg_n    = seg;
    cable_n  = cable;
    msg_a_n  = msg_a;
    beg_a_n  = beg_a;
    ovf_n    = ovf;
    hold_n   = hold;
    rd_ptr_n = rd_ptr;
    det_n    = det;
    if (data_rd && live && rd_ptr < seg_end) rd_ptr_n = rd_ptr + 1'b1;
    if (cmd_wr && cmd_code == CMD_REWIND)    rd_ptr_n = base;
    if (det_wr) det_n = det_wdata;
    if (beg_clr) begin
      beg_a_n = 1'b0;
      seg_n   = 1'b1;
      shown_n = 1'b0;
    end
    if (msg_clr) begin
      msg_a_n = 1'b0;
      hold_n  = 1'b0;
      cable_n = 1'b0;
      shown_n = 1'b0;
      seg_n   = 1'b0;
    end
    if (ovf_clr) ovf_n = 1'b0;
    if (ovf_evt) begin
      ovf_n  = 1'b1;
      hold_n = 1'b1;
    end
    if (!shown && head_valid && !cable && !beg_clr && !msg_clr) begin
      shown_n  = 1'b1;
      rd_ptr_n = base;
      if (!seg && is_long) beg_a_n = 1'b1;
      else                 msg_a_n = 1'b1;
    end
    if (cable_rst) begin
      cable_n  = 1'b1;
      msg_a_n  = 1'b1;
      beg_a_n  = 1'b0;
      shown_n  = 1'b0;
      seg_n    = 1'b0;
      rd_ptr_n = '0;
      det_n    = '0;
    end
    if (hard_rst) begin
      cable_n  = 1'b0;
      msg_a_n  = 1'b0;
      beg_a_n  = 1'b0;
      shown_n  = 1'b0;
      seg_n    = 1'b0;
      rd_ptr_n = '0;
      det_n    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown  <= 1'b0;
      seg    <= 1'b0;
      cable  <= 1'b0;
      msg_a  <= 1'b0;
      beg_a  <= 1'b0;
      ovf    <= 1'b0;
      hold   <= 1'b0;
      rd_ptr <= '0;
      det    <= '0;
    end else begin
      shown  <= shown_n;
      seg    <= seg_n;
      cable  <= cable_n;
      msg_a  <= msg_a_n;
      beg_a  <= beg_a_n;
      ovf    <= ovf_n;
      hold   <= hold_n;
      rd_ptr <= rd_ptr_n;
      det    <= det_n;
    end
  end

  assign alerts = {ovf, beg_a, msg_a};
  assign ack_en = hold ? '0 : det;

  p_one_seg_alert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(beg_a && msg_a));
  p_ptr_in_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (rd_ptr >= base && rd_ptr <= seg_end));
  p_ovf_needs_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(alert_wr && alert_wdata[ALB_MSG] && alert_wdata[ALB_OVF]));
  p_rewind_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == CMD_REWIND && live && !alert_wr && !hard_rst && !cable_rst)
      |=> rd_ptr == (seg ? LW'(SEG_FIRST) : '0));
endmodule

// File: rtl/pd_rx_seg_buffer.sv
module pd_rx_seg_buffer #(
  parameter int MAX_MSG   = 264,
  parameter int SEG_FIRST = 132,
  parameter int FT_W      = 3,
  parameter int N_ACK     = 3,
  parameter int CABLE_FT  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sof,
  input  logic [FT_W-1:0]  rx_ft,
  input  logic             rx_we,
  input  logic [7:0]       rx_wdata,
  input  logic             rx_eof,
  input  logic             rx_hard_rst,
  input  logic             rx_cable_rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [2:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic [N_ACK-1:0] ack_en
);
  import rxb_pkg::*;
  localparam int LW = $clog2(MAX_MSG + 1);

  logic             head_valid, free_head, ovf_evt;
  logic [LW-1:0]    head_len, rd_ptr;
  logic [FT_W-1:0]  head_ft, ftype;
  logic [7:0]       rd_byte, cnt;
  logic [2:0]       alerts;
  logic [N_ACK-1:0] det;
  logic             alert_wr, cmd_wr, det_wr, data_rd;

  assign alert_wr = host_wr & (host_addr == REG_ALERT);
  assign cmd_wr   = host_wr & (host_addr == REG_CMD);
  assign det_wr   = host_wr & (host_addr == REG_ACKEN);
  assign data_rd  = host_rd & (host_addr == REG_DATA);

  rxb_store #(.MAX_MSG(MAX_MSG), .FT_W(FT_W)) u_store (
    .clk, .rst_n, .rx_sof, .rx_ft, .rx_we, .rx_wdata, .rx_eof,
    .flush(rx_hard_rst | rx_cable_rst), .free_head, .rd_ptr,
    .head_valid, .head_len, .head_ft, .rd_byte, .ovf_evt
  );

  rxb_present #(.MAX_MSG(MAX_MSG), .SEG_FIRST(SEG_FIRST), .FT_W(FT_W),
                .N_ACK(N_ACK), .CABLE_FT(CABLE_FT)) u_present (
    .clk, .rst_n, .hard_rst(rx_hard_rst), .cable_rst(rx_cable_rst),
    .head_valid, .head_len, .head_ft, .ovf_evt,
    .alert_wr, .alert_wdata(host_wdata[2:0]), .cmd_wr, .cmd_code(host_wdata),
    .det_wr, .det_wdata(host_wdata[N_ACK-1:0]), .data_rd,
    .rd_ptr, .free_head, .cnt, .ftype, .alerts, .det, .ack_en
  );

  always_comb begin
    case (host_addr)
      REG_ALERT: host_rdata = {5'd0, alerts};
      REG_COUNT: host_rdata = cnt;
      REG_FTYPE: host_rdata = 8'(ftype);
      REG_DATA:  host_rdata = rd_byte;
      REG_ACKEN: host_rdata = 8'(det);
      default:   host_rdata = 8'd0;
    endcase
  end

  p_hard_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hard_rst |=> (cnt == 8'd0 && ack_en == '0));
  p_cable_marks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cable_rst && !rx_hard_rst) |=> (cnt == 8'd1 && alerts[ALB_MSG]));
endmodule

// File: tb/pd_rx_seg_buffer_bench.sv
module pd_rx_seg_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_sof, rx_we, rx_eof, rx_hard_rst, rx_cable_rst;
  logic [2:0] rx_ft;
  logic [7:0] rx_wdata;
  logic       host_wr, host_rd;
  logic [2:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic [2:0] ack_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pd_rx_seg_buffer u_pd_rx_seg_buffer (
    .clk, .rst_n, .rx_sof, .rx_ft, .rx_we, .rx_wdata, .rx_eof,
    .rx_hard_rst, .rx_cable_rst, .host_wr, .host_rd, .host_addr,
    .host_wdata, .host_rdata, .ack_en
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + (i >> 3)) & 255);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int ft, input int len, input int seed);
    rx_ft = 3'(ft); rx_sof = 1'b1; tick(); rx_sof = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_we = 1'b1; rx_wdata = pat(seed, i); tick();
    end
    rx_we = 1'b0; rx_eof = 1'b1; tick(); rx_eof = 1'b0;
  endtask

  task automatic rd(input int addr, output int val);
    host_addr = 3'(addr); host_rd = 1'b1; #1;
    val = int'(host_rdata);
    tick(); host_rd = 1'b0;
  endtask

  task automatic wr(input int addr, input int val);
    host_addr = 3'(addr); host_wdata = 8'(val); host_wr = 1'b1;
    tick(); host_wr = 1'b0;
  endtask

  task automatic expect_reg(input int addr, input int exp, input string tag);
    int v;
    rd(addr, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic expect_bytes(input int seed, input int from, input int n, input string tag);
    int v;
    for (int i = from; i < from + n; i++) begin
      rd(3, v);
      chk(v == int'(pat(seed, i)), tag, v, int'(pat(seed, i)));
    end
  endtask

  task automatic run_msg(input int ft, input int len, input int seed);
    bit lng;
    lng = len > 132;
    send(ft, len, seed); tick(); tick();
    expect_reg(0, lng ? 2 : 1, lng ? "R3 alert" : "R2 alert");
    expect_reg(1, lng ? 133 : len + 1, lng ? "R3 count" : "R2 count");
    expect_reg(2, ft, "R2 ftype");
    expect_bytes(seed, 0, lng ? 132 : len, lng ? "R3 data" : "R2 data");
    expect_reg(1, 1, "R5 count at end");
    if (lng) begin
      wr(0, 2); tick();
      expect_reg(0, 1, "R4 alert");
      expect_reg(1, len - 131, "R4 count");
      expect_bytes(seed, 132, len - 132, "R4 data");
    end
    wr(0, 1);
    expect_reg(1, 0, "R8 freed count");
    expect_reg(0, 0, "R8 freed alert");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int lens[11] = '{1, 2, 30, 100, 131, 132, 133, 134, 200, 263, 264};
    rst_n = 1'b0; rx_sof = 0; rx_we = 0; rx_eof = 0; rx_hard_rst = 0;
    rx_cable_rst = 0; rx_ft = 0; rx_wdata = 0; host_wr = 0; host_rd = 0;
    host_addr = 0; host_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1
    expect_reg(0, 0, "R1 alert");
    expect_reg(1, 0, "R1 count");
    expect_reg(2, 0, "R1 ftype");
    chk(ack_en == 3'd0, "R1 ack_en", int'(ack_en), 0);
    // R13
    wr(5, 7);
    chk(ack_en == 3'd7, "R13 ack_en", int'(ack_en), 7);
    expect_reg(5, 7, "R13 readback");

    // R2 R3 R4 sweep across the split boundary
    for (int k = 0; k < 11; k++) run_msg(k % 3, lens[k], k + 1);

    // R5 R6 R7 R8 on a 30-byte frame
    send(0, 30, 40); tick(); tick();
    expect_reg(2, 0, "R5 ftype read");
    expect_reg(1, 31, "R5 count read");
    expect_bytes(40, 0, 15, "R5 data after meta reads");
    expect_reg(1, 16, "R7 partial count");
    wr(4, 8'hEF);
    expect_bytes(40, 15, 1, "R6 other code ignored");
    wr(4, 8'hEE);
    expect_reg(1, 31, "R6 rewind count");
    expect_bytes(40, 0, 1, "R6 rewind data");
    wr(0, 2); wr(0, 4); wr(0, 0); tick();
    expect_reg(0, 1, "R8 ignored alert writes");
    expect_reg(1, 30, "R8 ignored writes count");
    expect_bytes(40, 1, 29, "R5 rest");
    rd(3, v);
    expect_reg(1, 1, "R5 read past end");
    wr(0, 1);

    // R6 rewind inside a tail segment
    send(1, 200, 41); tick(); tick();
    wr(0, 2); tick();
    expect_bytes(41, 132, 5, "R4 tail data");
    wr(4, 8'hEE);
    expect_reg(1, 69, "R6 tail rewind count");
    expect_bytes(41, 132, 1, "R6 tail rewind data");
    wr(0, 1);

    // R8 queued second frame
    send(1, 20, 42); send(2, 40, 43); tick(); tick();
    expect_reg(1, 21, "R8 first count");
    wr(0, 1); tick();
    expect_reg(0, 1, "R8 next alert");
    expect_reg(1, 41, "R8 next count");
    expect_reg(2, 2, "R8 next ftype");
    expect_bytes(43, 0, 40, "R8 next data");
    wr(0, 1);

    // R9 R10 overflow
    send(0, 264, 50); send(1, 30, 51); send(2, 10, 52); tick(); tick();
    expect_reg(0, 6, "R9 overflow with begin alert");
    chk(ack_en == 3'd0, "R10 ack muted", int'(ack_en), 0);
    expect_bytes(50, 0, 132, "R9 long frame intact");
    wr(0, 2); tick();
    expect_reg(0, 5, "R9 tail alert");
    expect_reg(1, 133, "R9 tail count");
    expect_bytes(50, 132, 132, "R9 tail data");
    chk(ack_en == 3'd0, "R10 ack still muted", int'(ack_en), 0);
    wr(0, 1); tick();
    expect_reg(0, 5, "R10 ovf kept by single clear");
    chk(ack_en == 3'd7, "R10 ack restored", int'(ack_en), 7);
    expect_reg(1, 31, "R9 second count");
    expect_reg(2, 1, "R9 second ftype");
    expect_bytes(51, 0, 30, "R9 second data");
    wr(0, 5); tick(); tick();
    expect_reg(0, 0, "R10 pair clear");
    expect_reg(1, 0, "R9 third dropped");

    // R11 hard reset
    send(0, 10, 60); tick(); tick();
    rx_hard_rst = 1'b1; tick(); rx_hard_rst = 1'b0;
    expect_reg(1, 0, "R11 count");
    expect_reg(0, 0, "R11 alert");
    chk(ack_en == 3'd0, "R11 ack_en", int'(ack_en), 0);
    expect_reg(5, 0, "R11 enable reg");
    tick(); tick();
    expect_reg(1, 0, "R11 nothing stored");
    wr(5, 7);

    // R12 cable reset
    send(2, 10, 61); tick(); tick();
    rx_cable_rst = 1'b1; tick(); rx_cable_rst = 1'b0;
    expect_reg(1, 1, "R12 count");
    expect_reg(2, 6, "R12 ftype");
    expect_reg(0, 1, "R12 alert");
    chk(ack_en == 3'd0, "R12 ack_en", int'(ack_en), 0);
    wr(0, 1); tick(); tick();
    expect_reg(1, 0, "R12 count after clear");
    expect_reg(0, 0, "R12 alert after clear");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule